// File: doc/BRIEF.md
# Debug Port Access Scan Register

This block is the target-side half of a debug port that sits behind a JTAG TAP. The TAP controller is outside the block and provides decoded strobes for instruction update, data capture, data shift and data update, all in the block's clock domain. From those strobes the block decodes a 4-bit instruction and implements three data registers:

- a 35-bit access register that carries debug-port and access-port register operations;
- a 32-bit identification register;
- a 1-bit bypass register.

On each access scan, a 3-bit request and a 32-bit word shift in. A 3-bit acknowledge and the read buffer shift out, so every read is posted: its result is collected on the following scan.

Debug-port registers live inside the block:

- a control/status word with sticky overrun and sticky error flags, an overrun-detect enable and power request/acknowledge bits;
- a select word holding an access-port selector and a bank;
- a read-buffer alias.

Access-port operations go out on a one-cycle request interface to an external register file. The block then stays busy for a programmable number of clocks. Any scan captured while busy acknowledges WAIT and has its update thrown away. While either sticky flag is set, access-port requests are dropped. An abort scan carrying the value 1 cancels an outstanding access.

Top module: `dbg_access_scan`

## Requirements
- R1: After reset, and one clock after any `tap_reset` pulse, the instruction register holds the IDCODE code 0xE. An IDCODE scan shifts out the 32-bit `IDCODE_VAL` parameter LSB first, and its bit 0 is 1.
- R2: Instruction codes: 0x8 selects abort, 0xA selects debug-port access, 0xB selects access-port access and 0xE selects IDCODE. Every other code selects a 1-bit bypass register that captures 0.
- R3: Access scans are 35 bits long and shift LSB first. Shifted in: bit 0 is RnW (1 = read), bits 2:1 are A[3:2], bits 34:3 are the write data. Shifted out: bits 2:0 are the acknowledge (OK = 3'b010, WAIT = 3'b001), bits 34:3 are the read buffer as captured.
- R4: A debug-port read loads the read buffer at update, so its value appears on the next access scan. Reading A=3 (read buffer) leaves the buffer unchanged.
- R5: Debug-port map by A[3:2]: 1 = control/status, 2 = select, 3 = read buffer. A=0 reads as 0, and writes to it are ignored.
- R6: Select keeps bits 31:24 (access-port selector) and bits 7:4 (bank); its other bits read 0. An access-port request carries `ap_addr` = {bank, A[3:2], 2'b00} and `ap_sel` = select[31:24].
- R7: An access-port operation raises `ap_req` for one clock and keeps the block busy for max(`ap_latency`,1) clocks. Any access or abort scan captured while busy returns WAIT. A read loads `ap_rdata` into the read buffer when it completes.
- R8: An access scan whose capture returned WAIT has its update discarded: no register write, no request and no read-buffer change. If control/status bit 0 (overrun detect) is 1, sticky overrun (bit 1) is set.
- R9: `ap_err` high on the completing clock of an access-port operation sets sticky error (control/status bit 5).
- R10: While control/status bit 1 or bit 5 is set, access-port scans issue no request. Debug-port scans still work.
- R11: Writing 1 to control/status bit 1 or bit 5 clears that flag. Writing 0 leaves it unchanged.
- R12: Control/status bit 0 and the power request bits 30 and 28 are writable. Bits 31 and 29 return the acknowledges of requests 30 and 28 one clock after they change. All other bits read 0.
- R13: An abort scan whose update carries RnW=0, A=0 and data 1 ends an outstanding access at once, without loading the read buffer. An abort scan with any other content has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| tap_reset | input | 1 | TAP test-logic-reset strobe |
| ir_update | input | 1 | Instruction update strobe |
| ir_in | input | 4 | Instruction value loaded on `ir_update` |
| dr_capture | input | 1 | Data-register capture strobe |
| dr_shift | input | 1 | Data-register shift enable, one bit per clock |
| dr_update | input | 1 | Data-register update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (LSB of the selected register) |
| ap_req | output | 1 | One-cycle access-port request |
| ap_write | output | 1 | Request is a write (held) |
| ap_sel | output | 8 | Access-port selector of the request (held) |
| ap_addr | output | 8 | Access-port register byte address (held) |
| ap_wdata | output | 32 | Write data of the request (held) |
| ap_rdata | input | 32 | Read data from the access port, sampled on completion |
| ap_err | input | 1 | Error from the access port, sampled on completion |
| ap_latency | input | LAT_W | Busy length of an access-port operation, in clocks |

## Verification
The bench goes after the posted-read timing. A design that loaded the buffer one scan late, or cleared it on a read-buffer read, would return the wrong word on the following scan. It issues a scan during a long access-port latency to check three things: that WAIT is returned, that the write is dropped rather than forwarded, and that sticky overrun is set. A design that acted on WAITed updates shows an extra request or a wrong flag. It then checks that access-port requests stay blocked while a sticky flag is set, and that writing 0 leaves the flags alone while writing 1 clears them. It also checks that an abort with a value other than 1 leaves the access running, while an abort with 1 ends it without touching the read buffer.

// File: rtl/dpscan_pkg.sv
package dpscan_pkg;
  localparam int IR_W = 4;
  localparam int DR_W = 35;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] IR_ABORT  = 4'h8;
  localparam logic [IR_W-1:0] IR_DPACC  = 4'hA;
  localparam logic [IR_W-1:0] IR_APACC  = 4'hB;
  localparam logic [IR_W-1:0] IR_IDCODE = 4'hE;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  typedef enum logic [1:0] {
    DPR_NONE  = 2'd0,
    DPR_CTRL  = 2'd1,
    DPR_SEL   = 2'd2,
    DPR_RDBUF = 2'd3
  } dp_reg_e;

  // request word as shifted in: RnW lands in bit 0
  typedef struct packed {
    logic [31:0] data;
    logic [1:0]  a;
    logic        rnw;
  } scan_req_t;

  function automatic logic [7:0] ap_byte_addr(logic [3:0] bank, logic [1:0] a);
    return {bank, a, 2'b00};
  endfunction

  function automatic logic [31:0] ctrl_word(logic det, logic orun, logic err,
                                            logic [1:0] preq, logic [1:0] pack);
    return {pack[1], preq[1], pack[0], preq[0], 22'b0, err, 3'b0, orun, det};
  endfunction

  function automatic logic [31:0] sel_word(logic [7:0] apsel, logic [3:0] bank);
    return {apsel, 16'b0, bank, 4'b0};
  endfunction
endpackage

// File: rtl/dpscan_shift.sv
module dpscan_shift import dpscan_pkg::*; #(
  parameter logic [ID_W-1:0] IDCODE_VAL = 32'h0A5C_3001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tap_reset,
  input  logic            ir_update,
  input  logic [IR_W-1:0] ir_in,
  input  logic            dr_capture,
  input  logic            dr_shift,
  input  logic            dr_update,
  input  logic            tdi,
  input  logic            busy,
  input  logic [31:0]     rdbuf,
  output logic            tdo,
  output scan_req_t       upd_req,
  output logic            upd_dp,
  output logic            upd_ap,
  output logic            upd_abort,
  output logic            upd_waited,
  output logic            acc_sel
);
  logic [IR_W-1:0] ir_q;
  logic [DR_W-1:0] sr;
  logic            cap_wait;
  logic            is_dp, is_ap, is_abort, is_id;

  assign is_dp    = (ir_q == IR_DPACC);
  assign is_ap    = (ir_q == IR_APACC);
  assign is_abort = (ir_q == IR_ABORT);
  assign is_id    = (ir_q == IR_IDCODE);
  assign acc_sel  = is_dp | is_ap | is_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q     <= IR_IDCODE;
      sr       <= '0;
      cap_wait <= 1'b0;
    end else begin
      if (tap_reset)      ir_q <= IR_IDCODE;
      else if (ir_update) ir_q <= ir_in;

      if (dr_capture) begin
        if (acc_sel) begin
          sr       <= {rdbuf, busy ? ACK_WAIT : ACK_OK};
          cap_wait <= busy;
        end else if (is_id) begin
          sr <= {{(DR_W-ID_W){1'b0}}, IDCODE_VAL};
        end else begin
          sr <= '0;
        end
      end else if (dr_shift) begin
        if (acc_sel)    sr <= {tdi, sr[DR_W-1:1]};
        else if (is_id) sr <= {{(DR_W-ID_W){1'b0}}, tdi, sr[ID_W-1:1]};
        else            sr <= {{(DR_W-1){1'b0}}, tdi};
      end
    end
  end

  assign tdo        = sr[0];
  assign upd_req    = scan_req_t'(sr);
  assign upd_dp     = dr_update & is_dp;
  assign upd_ap     = dr_update & is_ap;
  assign upd_abort  = dr_update & is_abort;
  assign upd_waited = cap_wait;

  // R1
  ir_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_reset |=> (ir_q == IR_IDCODE));
  // R2
  ir_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_dp, is_ap, is_abort, is_id}));
endmodule

// File: rtl/dpscan_regs.sv
module dpscan_regs import dpscan_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  scan_req_t   upd_req,
  input  logic        upd_dp,
  input  logic        upd_ap,
  input  logic        upd_abort,
  input  logic        upd_waited,
  input  logic        ap_done,
  input  logic        ap_done_rd,
  input  logic [31:0] ap_rdata,
  input  logic        ap_err,
  output logic [31:0] rdbuf,
  output logic [3:0]  sel_bank,
  output logic [7:0]  sel_ap,
  output logic        ap_issue,
  output logic        abort_go,
  output logic        sticky_any
);
  logic       orun_det, sticky_orun, sticky_err;
  logic [1:0] pwr_req, pwr_ack;
  logic       wait_upd, dp_go;
  dp_reg_e    dreg;

  assign dreg       = dp_reg_e'(upd_req.a);
  assign sticky_any = sticky_orun | sticky_err;
  assign wait_upd   = (upd_dp | upd_ap) & upd_waited;
  assign dp_go      = upd_dp & ~upd_waited;
  assign ap_issue   = upd_ap & ~upd_waited & ~sticky_any;
  assign abort_go   = upd_abort & ~upd_req.rnw & (upd_req.a == 2'd0)
                      & (upd_req.data == 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdbuf       <= '0;
      sel_bank    <= '0;
      sel_ap      <= '0;
      orun_det    <= 1'b0;
      sticky_orun <= 1'b0;
      sticky_err  <= 1'b0;
      pwr_req     <= '0;
      pwr_ack     <= '0;
    end else begin
      pwr_ack <= pwr_req;
      if (wait_upd && orun_det) sticky_orun <= 1'b1;
      if (ap_done && ap_err)    sticky_err  <= 1'b1;
      if (ap_done && ap_done_rd) rdbuf <= ap_rdata;
      if (dp_go) begin
        if (upd_req.rnw) begin
          unique case (dreg)
            DPR_NONE:  rdbuf <= '0;
            DPR_CTRL:  rdbuf <= ctrl_word(orun_det, sticky_orun, sticky_err, pwr_req, pwr_ack);
            DPR_SEL:   rdbuf <= sel_word(sel_ap, sel_bank);
            DPR_RDBUF: rdbuf <= rdbuf;
          endcase
        end else begin
          unique case (dreg)
            DPR_CTRL: begin
              orun_det <= upd_req.data[0];
              pwr_req  <= {upd_req.data[30], upd_req.data[28]};
              if (upd_req.data[1]) sticky_orun <= 1'b0;
              if (upd_req.data[5]) sticky_err  <= 1'b0;
            end
            DPR_SEL: begin
              sel_ap   <= upd_req.data[31:24];
              sel_bank <= upd_req.data[7:4];
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R8
  orun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_orun) |-> $past(wait_upd && orun_det));
  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_err) |-> $past(ap_done && ap_err));
  // R11
  orun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky_orun) |-> $past(dp_go && !upd_req.rnw && dreg == DPR_CTRL));
endmodule

// File: rtl/dpscan_apctl.sv
module dpscan_apctl import dpscan_pkg::*; #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             abort_go,
  input  scan_req_t        upd_req,
  input  logic [3:0]       sel_bank,
  input  logic [7:0]       sel_ap,
  input  logic [LAT_W-1:0] latency,
  output logic             ap_req,
  output logic             ap_write,
  output logic [7:0]       ap_sel,
  output logic [7:0]       ap_addr,
  output logic [31:0]      ap_wdata,
  output logic             busy,
  output logic             done,
  output logic             done_rd
);
  localparam logic [LAT_W-1:0] ONE = LAT_W'(1);
  logic [LAT_W-1:0] cnt;

  assign done    = busy && (cnt <= ONE) && !abort_go;
  assign done_rd = done && !ap_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_req   <= 1'b0;
      ap_write <= 1'b0;
      ap_sel   <= '0;
      ap_addr  <= '0;
      ap_wdata <= '0;
      busy     <= 1'b0;
      cnt      <= '0;
    end else begin
      ap_req <= 1'b0;
      if (issue) begin
        ap_req   <= 1'b1;
        ap_write <= ~upd_req.rnw;
        ap_sel   <= sel_ap;
        ap_addr  <= ap_byte_addr(sel_bank, upd_req.a);
        ap_wdata <= upd_req.data;
        busy     <= 1'b1;
        cnt      <= (latency == '0) ? ONE : latency;
      end else if (abort_go) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (cnt <= ONE) busy <= 1'b0;
        else            cnt  <= cnt - ONE;
      end
    end
  end

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ap_req);
  // R13
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done || abort_go));
endmodule

// File: rtl/dbg_access_scan.sv
module dbg_access_scan import dpscan_pkg::*; #(
  parameter logic [ID_W-1:0] IDCODE_VAL = 32'h0A5C_3001,
  parameter int              LAT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_reset,
  input  logic             ir_update,
  input  logic [IR_W-1:0]  ir_in,
  input  logic             dr_capture,
  input  logic             dr_shift,
  input  logic             dr_update,
  input  logic             tdi,
  output logic             tdo,
  output logic             ap_req,
  output logic             ap_write,
  output logic [7:0]       ap_sel,
  output logic [7:0]       ap_addr,
  output logic [31:0]      ap_wdata,
  input  logic [31:0]      ap_rdata,
  input  logic             ap_err,
  input  logic [LAT_W-1:0] ap_latency
);
  scan_req_t   upd_req;
  logic        upd_dp, upd_ap, upd_abort, upd_waited, acc_sel;
  logic        busy, done, done_rd;
  logic [31:0] rdbuf;
  logic [3:0]  sel_bank;
  logic [7:0]  sel_ap;
  logic        ap_issue, abort_go, sticky_any;

  dpscan_shift #(.IDCODE_VAL(IDCODE_VAL)) shift_i (
    .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .ir_update(ir_update),
    .ir_in(ir_in), .dr_capture(dr_capture), .dr_shift(dr_shift),
    .dr_update(dr_update), .tdi(tdi), .busy(busy), .rdbuf(rdbuf), .tdo(tdo),
    .upd_req(upd_req), .upd_dp(upd_dp), .upd_ap(upd_ap), .upd_abort(upd_abort),
    .upd_waited(upd_waited), .acc_sel(acc_sel));

  dpscan_regs regs_i (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_dp(upd_dp),
    .upd_ap(upd_ap), .upd_abort(upd_abort), .upd_waited(upd_waited),
    .ap_done(done), .ap_done_rd(done_rd), .ap_rdata(ap_rdata), .ap_err(ap_err),
    .rdbuf(rdbuf), .sel_bank(sel_bank), .sel_ap(sel_ap), .ap_issue(ap_issue),
    .abort_go(abort_go), .sticky_any(sticky_any));

  dpscan_apctl #(.LAT_W(LAT_W)) apctl_i (
    .clk(clk), .rst_n(rst_n), .issue(ap_issue), .abort_go(abort_go),
    .upd_req(upd_req), .sel_bank(sel_bank), .sel_ap(sel_ap),
    .latency(ap_latency), .ap_req(ap_req), .ap_write(ap_write),
    .ap_sel(ap_sel), .ap_addr(ap_addr), .ap_wdata(ap_wdata), .busy(busy),
    .done(done), .done_rd(done_rd));

  // R10
  no_req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_req |-> !$past(sticky_any));
  // R3
  wait_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_capture && acc_sel && busy) |=> tdo);
endmodule

// File: tb/dbg_access_scan_tb_top.sv
module dbg_access_scan_tb_top;
  logic clk = 0, rst_n = 0;
  logic tap_reset = 0, ir_update = 0, dr_capture = 0, dr_shift = 0, dr_update = 0, tdi = 0;
  logic [3:0] ir_in = 0;
  logic tdo, ap_req, ap_write;
  logic [7:0] ap_sel, ap_addr;
  logic [31:0] ap_wdata, ap_rdata;
  logic ap_err;
  logic [7:0] ap_latency = 8'd2;

  int n_chk = 0, n_fail = 0, req_cnt = 0;
  logic [7:0] last_addr, last_sel;
  logic [31:0] mem [64];
  logic [31:0] mdl [64];
  logic [3:0] cur_ir;
  bit finished = 0;

  always #5 clk = ~clk;

  dbg_access_scan dut_i (
    .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .ir_update(ir_update),
    .ir_in(ir_in), .dr_capture(dr_capture), .dr_shift(dr_shift),
    .dr_update(dr_update), .tdi(tdi), .tdo(tdo), .ap_req(ap_req),
    .ap_write(ap_write), .ap_sel(ap_sel), .ap_addr(ap_addr),
    .ap_wdata(ap_wdata), .ap_rdata(ap_rdata), .ap_err(ap_err),
    .ap_latency(ap_latency));

  // access-port stub
  assign ap_rdata = mem[ap_addr[7:2]];
  assign ap_err   = (ap_addr == 8'hFC);
  always @(posedge clk) if (ap_req) begin
    req_cnt <= req_cnt + 1;
    last_addr <= ap_addr;
    last_sel <= ap_sel;
    if (ap_write) mem[ap_addr[7:2]] <= ap_wdata;
  end

  function automatic logic [31:0] init_val(int i);
    return (32'(i) * 32'h0101_0107) ^ 32'hC3C3_0000;
  endfunction
  function automatic logic [31:0] exp_sel(logic [31:0] d);
    return {d[31:24], 16'h0, d[7:4], 4'h0};
  endfunction
  function automatic logic [31:0] exp_ctrl(bit det, bit orun, bit err, bit sreq, bit dreq);
    logic [31:0] v = 0;
    v[0] = det; v[1] = orun; v[5] = err;
    v[31] = sreq; v[30] = sreq; v[29] = dreq; v[28] = dreq;
    return v;
  endfunction

  task automatic chk(string req, logic [34:0] act, logic [34:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ir_load(logic [3:0] code);
    @(negedge clk); ir_in = code; ir_update = 1;
    @(negedge clk); ir_update = 0;
    cur_ir = code;
  endtask

  task automatic scan(int n, logic [34:0] din, output logic [34:0] dout);
    dout = '0;
    @(negedge clk); dr_capture = 1;
    @(negedge clk); dr_capture = 0; dr_shift = 1;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      @(negedge clk);
    end
    dr_shift = 0; dr_update = 1;
    @(negedge clk); dr_update = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic op(logic [3:0] ir, logic [1:0] a, logic rnw, logic [31:0] d,
                    output logic [2:0] ack, output logic [31:0] prev);
    logic [34:0] r;
    if (cur_ir !== ir) ir_load(ir);
    scan(35, {d, a, rnw}, r);
    ack = r[2:0];
    prev = r[34:3];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [34:0] r;
    logic [2:0] ack;
    logic [31:0] prev, rb_m, sel_m;
    int rc;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin mem[i] = init_val(i); mdl[i] = init_val(i); end
    cur_ir = 4'hE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state: IDCODE selected
    chk("R1 tdo after reset", {34'b0, tdo}, 35'd0);
    scan(32, 35'd0, r);
    chk("R1 idcode after reset", r, {3'b0, 32'h0A5C_3001});
    ir_load(4'h3);
    // R2 bypass captures 0, one bit long
    scan(2, 35'b01, r);
    chk("R2 bypass", r, 35'b10);
    @(negedge clk); tap_reset = 1; @(negedge clk); tap_reset = 0; cur_ir = 4'hE;
    scan(32, 35'd0, r);
    chk("R1 idcode after tap reset", r, {3'b0, 32'h0A5C_3001});

    // R3 R6 select write and posted read
    op(4'hA, 2'd2, 0, 32'h5A12_34C7, ack, prev);
    chk("R3 ack ok", {32'b0, ack}, {32'b0, 3'b010});
    op(4'hA, 2'd2, 1, 32'h0, ack, prev);
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R6 select readback", {3'b0, prev}, {3'b0, 32'h5A00_00C0});
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R4 rdbuff no side effect", {3'b0, prev}, {3'b0, 32'h5A00_00C0});
    op(4'hA, 2'd0, 0, 32'hFFFF_FFFF, ack, prev);
    op(4'hA, 2'd0, 1, 32'h0, ack, prev);
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R5 reserved reads 0", {3'b0, prev}, 35'd0);

    // R12 control/status writable bits and power acks
    op(4'hA, 2'd1, 0, 32'h5000_0001 | 32'h0F00_F000, ack, prev);
    op(4'hA, 2'd1, 1, 32'h0, ack, prev);
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R12 ctrl power", {3'b0, prev}, {3'b0, exp_ctrl(1, 0, 0, 1, 1)});

    // R6 R7 access-port write then read
    op(4'hB, 2'd1, 0, 32'hBEEF_0011, ack, prev);
    chk("R6 ap addr", {27'b0, last_addr}, {27'b0, 8'hC4});
    chk("R6 ap sel", {27'b0, last_sel}, {27'b0, 8'h5A});
    op(4'hB, 2'd1, 1, 32'h0, ack, prev);
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R7 ap read in buffer", {3'b0, prev}, {3'b0, 32'hBEEF_0011});

    // R7 R8 WAIT with overrun detect on
    ap_latency = 8'd200;
    op(4'hB, 2'd2, 0, 32'h1111_2222, ack, prev);
    rc = req_cnt;
    op(4'hB, 2'd3, 0, 32'h3333_4444, ack, prev);
    chk("R7 wait ack", {32'b0, ack}, {32'b0, 3'b001});
    chk("R8 no request on wait", 35'(req_cnt), 35'(rc));
    repeat (210) @(negedge clk);
    ap_latency = 8'd2;
    chk("R8 write dropped", {3'b0, mem[6'h33]}, {3'b0, init_val(6'h33)});
    op(4'hA, 2'd1, 1, 32'h0, ack, prev);
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R8 sticky overrun", {3'b0, prev}, {3'b0, exp_ctrl(1, 1, 0, 1, 1)});

    // R10 access-port dropped while sticky
    rc = req_cnt;
    op(4'hB, 2'd0, 1, 32'h0, ack, prev);
    chk("R10 ap dropped", 35'(req_cnt), 35'(rc));

    // R11 write 0 keeps, write 1 clears
    op(4'hA, 2'd1, 0, 32'h5000_0001, ack, prev);
    op(4'hA, 2'd1, 1, 32'h0, ack, prev);
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R11 write 0 keeps", {3'b0, prev}, {3'b0, exp_ctrl(1, 1, 0, 1, 1)});
    op(4'hA, 2'd1, 0, 32'h5000_0003, ack, prev);
    op(4'hA, 2'd1, 1, 32'h0, ack, prev);
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R11 write 1 clears", {3'b0, prev}, {3'b0, exp_ctrl(1, 0, 0, 1, 1)});

    // R9 access-port error
    op(4'hA, 2'd2, 0, 32'h0000_00F0, ack, prev);
    op(4'hB, 2'd3, 1, 32'h0, ack, prev);
    op(4'hA, 2'd1, 1, 32'h0, ack, prev);
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R9 sticky error", {3'b0, prev}, {3'b0, exp_ctrl(1, 0, 1, 1, 1)});
    op(4'hA, 2'd1, 0, 32'h5000_0021, ack, prev);
    op(4'hA, 2'd2, 0, 32'h0, ack, prev);
    op(4'hA, 2'd1, 1, 32'h0, ack, prev);
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R11 error cleared", {3'b0, prev}, {3'b0, exp_ctrl(1, 0, 0, 1, 1)});

    // R13 abort
    ap_latency = 8'd200;
    op(4'hB, 2'd1, 1, 32'h0, ack, prev);
    op(4'h8, 2'd0, 0, 32'h2, ack, prev);
    op(4'h8, 2'd0, 0, 32'h1, ack, prev);
    chk("R13 bad abort ignored", {32'b0, ack}, {32'b0, 3'b001});
    op(4'hA, 2'd3, 1, 32'h0, ack, prev);
    chk("R13 abort ends busy", {32'b0, ack}, {32'b0, 3'b010});
    chk("R13 buffer untouched", {3'b0, prev}, {3'b0, exp_ctrl(1, 0, 0, 1, 1)});
    ap_latency = 8'd2;

    // random mix, R4 R6 R7
    mdl[6'h31] = 32'hBEEF_0011;
    rb_m = exp_ctrl(1, 0, 0, 1, 1);
    sel_m = 32'h0;
    for (int k = 0; k < 40; k++) begin
      int kind = $urandom % 4;
      logic [31:0] d = $urandom;
      logic [1:0] a = 2'($urandom % 4);
      ap_latency = 8'(1 + $urandom % 3);
      case (kind)
        0: begin
          d[7:4] = 4'($urandom % 15);
          op(4'hA, 2'd2, 0, d, ack, prev);
          sel_m = exp_sel(d);
        end
        1: begin op(4'hA, 2'd2, 1, 0, ack, prev); end
        2: begin op(4'hB, a, 0, d, ack, prev); mdl[{sel_m[7:4], a}] = d; end
        default: begin op(4'hB, a, 1, 0, ack, prev); end
      endcase
      chk("R3 random ack", {32'b0, ack}, {32'b0, 3'b010});
      chk("R4 random posted data", {3'b0, prev}, {3'b0, rb_m});
      if (kind == 1) rb_m = sel_m;
      if (kind == 3) rb_m = mdl[{sel_m[7:4], a}];
    end
    op(4'hA, 2'd3, 1, 0, ack, prev);
    chk("R7 random final", {3'b0, prev}, {3'b0, rb_m});

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule